// File: doc/BRIEF.md
# Two-Bank Line Store Buffer

This block sits between a set of load/store units and a pair of 128-bit cache ports. Each unit owns two request ports: one for the aligned part of an access and one for the remainder that spills into the next 16-byte line. Each request carries an address, a read/write flag, sixteen byte enables and 128 bits of write data. Address bit 4 steers each request to one of two banks. Every bank keeps one 128-bit slot per unit, so with the default of eight units each bank holds eight entries.

Each bank issues at most one cache operation per clock, either a read or a write, over a valid/ready channel. The lowest-numbered pending unit wins. A winning write takes along every other pending write in the same bank that targets the same line. Their byte enables are ORed, and on overlapping bytes the higher unit index supplies the data. A read that completes its handshake returns its data to the port that issued it on the next cycle.

Back-pressure rules. A unit's request pair is taken when `pr_valid` and `pr_ready` are both high on a clock edge. `pr_ready` is high only while the unit holds nothing in either bank. On the cache side, once `cq_valid` is raised, the operation and all its fields hold still until `cq_ready` is sampled high. A slot is freed only by that handshake. Read data on `cq_rdata` is taken in the handshake cycle.

Top module: `l0buf`

## Requirements
- R1: A request whose address bit 4 is 0 is stored in bank 0, and one with bit 4 set is stored in bank 1. The bank presents the line address on `cq_addr` with bits 3:0 zero.
- R2: `pr_ready[u]` is high exactly when unit u has no entry pending in either bank. A pair taken with neither port enabled stores nothing.
- R3: If both ports of a unit are enabled and their address bits 48 down to 12 differ, the pair is consumed but nothing is stored, and `pair_err[u]` is high for the one cycle after the handshake.
- R4: If both ports of a unit are enabled and both addresses carry the same bit 4, the pair is rejected in the same way as in R3.
- R5: Among the pending entries of a bank, the lowest unit index is issued first. `cq_valid` is high whenever a bank has any pending entry.
- R6: When the issued entry is a write, every pending write in that bank with the same line address joins it. `cq_be` is the OR of their enables, and each enabled byte of `cq_wdata` comes from the highest-indexed member enabling it. Disabled bytes are zero. A read is issued alone, with its own byte enables.
- R7: While `cq_valid` is high and `cq_ready` low, the next cycle presents the same `cq_we`, `cq_addr`, `cq_be` and `cq_wdata`, even if new entries arrive.
- R8: `busy[p]` (p = 2*unit + side, where side 0 is the aligned port and side 1 the spill port) is high from the cycle after port p's request is stored until the cycle after its cache handshake. All members of a merged write are freed by one handshake.
- R9: After a read handshake, `ld_valid[p]` of the issuing port is high for exactly one cycle, and `ld_data[p]` carries the `cq_rdata` sampled at the handshake.
- R10: After reset, all `pr_ready` are high and all `cq_valid`, `busy`, `ld_valid` and `pair_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pr_valid | input | NUNIT | Unit offers a request pair |
| pr_ready | output | NUNIT | Unit may hand over a pair |
| pp_en | input | 2*NUNIT | Port carries a request (index 2*unit+side) |
| pp_we | input | 2*NUNIT | 1 = write, 0 = read |
| pp_addr | input | 2*NUNIT x AW | Byte address per port |
| pp_be | input | 2*NUNIT x DW/8 | Byte enables per port |
| pp_wdata | input | 2*NUNIT x DW | Write data per port |
| busy | output | 2*NUNIT | Port has an entry pending |
| pair_err | output | NUNIT | Rejected pair, one-cycle pulse |
| ld_valid | output | 2*NUNIT | Read data returned to port |
| ld_data | output | 2*NUNIT x DW | Returned read data |
| cq_valid | output | 2 | Bank offers a cache operation |
| cq_ready | input | 2 | Cache accepts the operation |
| cq_we | output | 2 | Operation is a write |
| cq_addr | output | 2 x AW | Line address, low four bits zero |
| cq_be | output | 2 x DW/8 | Merged byte enables |
| cq_wdata | output | 2 x DW | Merged write data |
| cq_rdata | input | 2 x DW | Read data, valid in the handshake cycle |

## Verification
`pr_ready` and every `cq_*` output depend only on registered state and settle within the cycle in which that state exists. `busy`, `pair_err` and `ld_valid`/`ld_data` change one edge after the handshake that causes them. The bench drives inputs on the falling edge and compares every output 1 ns later against a behavioural model. The model advances right after each rising edge, using the inputs that were in force at that edge. As a result, combinational results are compared in the cycle they are due and registered results one cycle after their cause. Random cache back-pressure exercises the hold rule, and a small pool of upper address values makes line merges and pair faults frequent.

// File: rtl/l0buf_pkg.sv
package l0buf_pkg;
  localparam int unsigned DEF_UNITS  = 8;
  localparam int unsigned DEF_AW     = 49;
  localparam int unsigned DEF_DW     = 128;
  localparam int unsigned DEF_CHK_LO = 12;

  typedef enum logic {
    SIDE_ALIGN = 1'b0,
    SIDE_SPILL = 1'b1
  } side_e;
endpackage

// File: rtl/l0buf_steer.sv
module l0buf_steer #(
  parameter int unsigned AW     = 49,
  parameter int unsigned OFF    = 4,
  parameter int unsigned CHK_LO = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [1:0]    en,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          bad,
  output logic [1:0]    load,
  output logic [1:0]    src_side
);
  logic tgt_a, tgt_b, mismatch, clash, fire;
  logic unused_low;

  assign tgt_a    = addr_a[OFF];
  assign tgt_b    = addr_b[OFF];
  assign mismatch = (&en) && (addr_a[AW-1:CHK_LO] != addr_b[AW-1:CHK_LO]);
  assign clash    = (&en) && (tgt_a == tgt_b);
  assign bad      = mismatch || clash;
  assign fire     = take && !bad;

  assign load[0]     = fire && ((en[0] && !tgt_a) || (en[1] && !tgt_b));
  assign load[1]     = fire && ((en[0] &&  tgt_a) || (en[1] &&  tgt_b));
  assign src_side[0] = en[1] && !tgt_b;
  assign src_side[1] = en[1] &&  tgt_b;

  assign unused_low = ^{addr_a[CHK_LO-1:0], addr_b[CHK_LO-1:0]};

  // a pair landing in both banks always shares its upper bits
  assert_pair_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load[0] && load[1]) |-> (addr_a[AW-1:CHK_LO] == addr_b[AW-1:CHK_LO]));
  // R4: a pair never feeds one bank twice, so both loads imply different bank bits
  assert_split_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load[0] && load[1]) |-> (en == 2'b11));
endmodule

// File: rtl/l0buf_pick.sv
module l0buf_pick #(
  parameter int unsigned NUNIT = 8,
  parameter int unsigned LW    = 45
) (
  input  logic [NUNIT-1:0]         valid,
  input  logic [NUNIT-1:0]         we,
  input  logic [NUNIT-1:0][LW-1:0] line,
  output logic [NUNIT-1:0]         mask
);
  logic          found;
  logic          win_we;
  logic [LW-1:0] win_line;

  always_comb begin
    mask     = '0;
    found    = 1'b0;
    win_we   = 1'b0;
    win_line = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (valid[u] && !found) begin
        found    = 1'b1;
        mask[u]  = 1'b1;
        win_we   = we[u];
        win_line = line[u];
      end
    end
    for (int u = 0; u < NUNIT; u++) begin
      if (win_we && valid[u] && we[u] && (line[u] == win_line)) mask[u] = 1'b1;
    end
  end
endmodule

// File: rtl/l0buf_merge.sv
module l0buf_merge #(
  parameter int unsigned NUNIT = 8,
  parameter int unsigned LW    = 45,
  parameter int unsigned DW    = 128
) (
  input  logic [NUNIT-1:0]           mask,
  input  logic [NUNIT-1:0]           we,
  input  logic [NUNIT-1:0][LW-1:0]   line,
  input  logic [NUNIT-1:0][DW/8-1:0] be,
  input  logic [NUNIT-1:0][DW-1:0]   data,
  output logic                       out_we,
  output logic [LW-1:0]              out_line,
  output logic [DW/8-1:0]            out_be,
  output logic [DW-1:0]              out_data
);
  localparam int unsigned BEW = DW / 8;
  logic taken;

  always_comb begin
    out_we   = 1'b0;
    out_line = '0;
    out_be   = '0;
    out_data = '0;
    taken    = 1'b0;
    for (int u = 0; u < NUNIT; u++) begin
      if (mask[u]) begin
        if (!taken) begin
          taken    = 1'b1;
          out_we   = we[u];
          out_line = line[u];
        end
        out_be = out_be | be[u];
        for (int k = 0; k < BEW; k++) begin
          if (be[u][k]) out_data[8*k +: 8] = data[u][8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/l0buf_bank.sv
module l0buf_bank #(
  parameter int unsigned NUNIT = 8,
  parameter int unsigned AW    = 49,
  parameter int unsigned DW    = 128,
  parameter int unsigned OFF   = 4,
  parameter int unsigned BANK  = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUNIT-1:0]               load,
  input  logic [NUNIT-1:0]               load_side,
  input  logic [NUNIT-1:0]               load_we,
  input  logic [NUNIT-1:0][AW-OFF-1:0]   load_line,
  input  logic [NUNIT-1:0][DW/8-1:0]     load_be,
  input  logic [NUNIT-1:0][DW-1:0]       load_data,
  output logic [NUNIT-1:0]               slot_valid,
  output logic [NUNIT-1:0]               slot_side,
  output logic                           c_valid,
  input  logic                           c_ready,
  output logic                           c_we,
  output logic [AW-1:0]                  c_addr,
  output logic [DW/8-1:0]                c_be,
  output logic [DW-1:0]                  c_wdata,
  input  logic [DW-1:0]                  c_rdata,
  output logic [NUNIT-1:0]               rsp_mask,
  output logic                           rsp_side,
  output logic [DW-1:0]                  rsp_data
);
  localparam int unsigned LW  = AW - OFF;
  localparam int unsigned BEW = DW / 8;

  logic [NUNIT-1:0]          ent_v, ent_side, ent_we;
  logic [NUNIT-1:0][LW-1:0]  ent_line;
  logic [NUNIT-1:0][BEW-1:0] ent_be;
  logic [NUNIT-1:0][DW-1:0]  ent_data;
  logic [NUNIT-1:0]          pick_mask, sel_mask, hold_mask_q, rsp_mask_q;
  logic                      hold_q, rsp_side_q, c_fire;
  logic [DW-1:0]             rsp_data_q;
  logic [LW-1:0]             out_line;

  l0buf_pick #(.NUNIT(NUNIT), .LW(LW)) u_pick (
    .valid(ent_v), .we(ent_we), .line(ent_line), .mask(pick_mask)
  );

  assign sel_mask = hold_q ? hold_mask_q : pick_mask;
  assign c_valid  = |sel_mask;
  assign c_fire   = c_valid && c_ready;

  l0buf_merge #(.NUNIT(NUNIT), .LW(LW), .DW(DW)) u_merge (
    .mask(sel_mask), .we(ent_we), .line(ent_line), .be(ent_be), .data(ent_data),
    .out_we(c_we), .out_line(out_line), .out_be(c_be), .out_data(c_wdata)
  );
  assign c_addr = {out_line, {OFF{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v       <= '0;
      hold_q      <= 1'b0;
      hold_mask_q <= '0;
      rsp_mask_q  <= '0;
      rsp_side_q  <= 1'b0;
    end else begin
      for (int u = 0; u < NUNIT; u++) begin
        if (load[u])                     ent_v[u] <= 1'b1;
        else if (c_fire && sel_mask[u])  ent_v[u] <= 1'b0;
      end
      hold_q      <= c_valid && !c_ready;
      hold_mask_q <= sel_mask;
      rsp_mask_q  <= (c_fire && !c_we) ? sel_mask : '0;
      rsp_side_q  <= |(sel_mask & ent_side);
    end
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUNIT; u++) begin
      if (load[u]) begin
        ent_side[u] <= load_side[u];
        ent_we[u]   <= load_we[u];
        ent_line[u] <= load_line[u];
        ent_be[u]   <= load_be[u];
        ent_data[u] <= load_data[u];
      end
    end
    if (c_fire && !c_we) rsp_data_q <= c_rdata;
  end

  assign slot_valid = ent_v;
  assign slot_side  = ent_side;
  assign rsp_mask   = rsp_mask_q;
  assign rsp_side   = rsp_side_q;
  assign rsp_data   = rsp_data_q;

  for (genvar u = 0; u < NUNIT; u++) begin : g_chk
    assert_bank_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load[u] |-> (load_line[u][0] == 1'(BANK)));
  end

  assert_load_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load & ent_v) == '0);
  assert_pick_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_mask & ~ent_v) == '0) && ((|ent_v) == c_valid));
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_we) && $stable(c_addr)
                               && $stable(c_be) && $stable(c_wdata)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_fire |=> ((ent_v & $past(sel_mask)) == '0));
  assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_mask_q));
endmodule

// File: rtl/l0buf.sv
module l0buf
  import l0buf_pkg::*;
#(
  parameter int unsigned NUNIT  = DEF_UNITS,
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned CHK_LO = DEF_CHK_LO
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUNIT-1:0]                 pr_valid,
  output logic [NUNIT-1:0]                 pr_ready,
  input  logic [2*NUNIT-1:0]               pp_en,
  input  logic [2*NUNIT-1:0]               pp_we,
  input  logic [2*NUNIT-1:0][AW-1:0]       pp_addr,
  input  logic [2*NUNIT-1:0][DW/8-1:0]     pp_be,
  input  logic [2*NUNIT-1:0][DW-1:0]       pp_wdata,
  output logic [2*NUNIT-1:0]               busy,
  output logic [NUNIT-1:0]                 pair_err,
  output logic [2*NUNIT-1:0]               ld_valid,
  output logic [2*NUNIT-1:0][DW-1:0]       ld_data,
  output logic [1:0]                       cq_valid,
  input  logic [1:0]                       cq_ready,
  output logic [1:0]                       cq_we,
  output logic [1:0][AW-1:0]               cq_addr,
  output logic [1:0][DW/8-1:0]             cq_be,
  output logic [1:0][DW-1:0]               cq_wdata,
  input  logic [1:0][DW-1:0]               cq_rdata
);
  localparam int unsigned BEW = DW / 8;
  localparam int unsigned OFF = $clog2(BEW);
  localparam int unsigned LW  = AW - OFF;

  logic [1:0][NUNIT-1:0]          bk_load, bk_side, bk_we, slot_v, slot_side, rsp_mask;
  logic [1:0][NUNIT-1:0][LW-1:0]  bk_line;
  logic [1:0][NUNIT-1:0][BEW-1:0] bk_be;
  logic [1:0][NUNIT-1:0][DW-1:0]  bk_data;
  logic [1:0]                     rsp_side;
  logic [1:0][DW-1:0]             rsp_data;
  logic [NUNIT-1:0]               bad_vec, err_q;
  logic                           unused_offs;

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [1:0] ld_b, sd_b;

    l0buf_steer #(.AW(AW), .OFF(OFF), .CHK_LO(CHK_LO)) u_steer (
      .clk(clk), .rst_n(rst_n),
      .take(pr_valid[u] && pr_ready[u]),
      .en(pp_en[2*u +: 2]),
      .addr_a(pp_addr[2*u]), .addr_b(pp_addr[2*u+1]),
      .bad(bad_vec[u]), .load(ld_b), .src_side(sd_b)
    );

    assign pr_ready[u] = !(slot_v[0][u] || slot_v[1][u]);

    for (genvar b = 0; b < 2; b++) begin : g_route
      assign bk_load[b][u] = ld_b[b];
      assign bk_side[b][u] = sd_b[b];
      assign bk_we[b][u]   = sd_b[b] ? pp_we[2*u+1]            : pp_we[2*u];
      assign bk_line[b][u] = sd_b[b] ? pp_addr[2*u+1][AW-1:OFF] : pp_addr[2*u][AW-1:OFF];
      assign bk_be[b][u]   = sd_b[b] ? pp_be[2*u+1]            : pp_be[2*u];
      assign bk_data[b][u] = sd_b[b] ? pp_wdata[2*u+1]         : pp_wdata[2*u];
    end

    assign busy[2*u]   = (slot_v[0][u] && slot_side[0][u] == SIDE_ALIGN)
                      || (slot_v[1][u] && slot_side[1][u] == SIDE_ALIGN);
    assign busy[2*u+1] = (slot_v[0][u] && slot_side[0][u] == SIDE_SPILL)
                      || (slot_v[1][u] && slot_side[1][u] == SIDE_SPILL);

    assign ld_valid[2*u]   = (rsp_mask[0][u] && rsp_side[0] == SIDE_ALIGN)
                          || (rsp_mask[1][u] && rsp_side[1] == SIDE_ALIGN);
    assign ld_valid[2*u+1] = (rsp_mask[0][u] && rsp_side[0] == SIDE_SPILL)
                          || (rsp_mask[1][u] && rsp_side[1] == SIDE_SPILL);
    assign ld_data[2*u]    = (rsp_mask[0][u] && rsp_side[0] == SIDE_ALIGN) ? rsp_data[0] : rsp_data[1];
    assign ld_data[2*u+1]  = (rsp_mask[0][u] && rsp_side[0] == SIDE_SPILL) ? rsp_data[0] : rsp_data[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= pr_valid & pr_ready & bad_vec;
  end
  assign pair_err = err_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    l0buf_bank #(.NUNIT(NUNIT), .AW(AW), .DW(DW), .OFF(OFF), .BANK(b)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .load(bk_load[b]), .load_side(bk_side[b]), .load_we(bk_we[b]),
      .load_line(bk_line[b]), .load_be(bk_be[b]), .load_data(bk_data[b]),
      .slot_valid(slot_v[b]), .slot_side(slot_side[b]),
      .c_valid(cq_valid[b]), .c_ready(cq_ready[b]), .c_we(cq_we[b]),
      .c_addr(cq_addr[b]), .c_be(cq_be[b]), .c_wdata(cq_wdata[b]),
      .c_rdata(cq_rdata[b]),
      .rsp_mask(rsp_mask[b]), .rsp_side(rsp_side[b]), .rsp_data(rsp_data[b])
    );
  end

  always_comb begin
    unused_offs = 1'b0;
    for (int p = 0; p < 2*NUNIT; p++) unused_offs = unused_offs ^ (^pp_addr[p][OFF-1:0]);
  end

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_err & ~$past(pr_valid & pr_ready)) == '0);
  assert_err_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_err & pr_ready) == pair_err);
endmodule

// File: tb/l0buf_tb.sv
`timescale 1ns/1ps
module l0buf_tb;
  localparam int NU = 8;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NU-1:0]         pr_valid, pr_ready, pair_err;
  logic [NP-1:0]         pp_en, pp_we, busy, ld_valid;
  logic [NP-1:0][48:0]   pp_addr;
  logic [NP-1:0][15:0]   pp_be;
  logic [NP-1:0][127:0]  pp_wdata, ld_data;
  logic [1:0]            cq_valid, cq_ready, cq_we;
  logic [1:0][48:0]      cq_addr;
  logic [1:0][15:0]      cq_be;
  logic [1:0][127:0]     cq_wdata, cq_rdata;

  always #4 clk = ~clk;

  l0buf u_dut (
    .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_ready(pr_ready),
    .pp_en(pp_en), .pp_we(pp_we), .pp_addr(pp_addr), .pp_be(pp_be), .pp_wdata(pp_wdata),
    .busy(busy), .pair_err(pair_err), .ld_valid(ld_valid), .ld_data(ld_data),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_we(cq_we), .cq_addr(cq_addr),
    .cq_be(cq_be), .cq_wdata(cq_wdata), .cq_rdata(cq_rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit           mv[2][NU], mside[2][NU], mwe[2][NU];
  logic [48:0]  maddr[2][NU];
  logic [15:0]  mbe[2][NU];
  logic [127:0] mdat[2][NU];
  bit           mhold[2];
  bit [NU-1:0]  mhm[2];
  bit           eld[NP];
  logic [127:0] eldd[NP];
  bit           eerr[NU];
  logic [36:0]  upool[2];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [NU-1:0] exp_mask(int b);
    bit [NU-1:0] m = '0;
    int w = -1;
    if (mhold[b]) return mhm[b];
    for (int u = 0; u < NU; u++) if (mv[b][u] && w < 0) w = u;
    if (w < 0) return m;
    m[w] = 1'b1;
    if (mwe[b][w])
      for (int u = 0; u < NU; u++)
        if (mv[b][u] && mwe[b][u] && maddr[b][u][48:4] == maddr[b][w][48:4]) m[u] = 1'b1;
    return m;
  endfunction

  function automatic int lowest(bit [NU-1:0] m);
    for (int u = 0; u < NU; u++) if (m[u]) return u;
    return 0;
  endfunction

  task automatic compare_all();
    for (int u = 0; u < NU; u++) begin
      chk($sformatf("R2 pr_ready[%0d]", u), pr_ready[u], !(mv[0][u] || mv[1][u]));
      chk($sformatf("R3 R4 pair_err[%0d]", u), pair_err[u], eerr[u]);
    end
    for (int p = 0; p < NP; p++) begin
      bit eb = 0;
      for (int b = 0; b < 2; b++)
        if (mv[b][p/2] && mside[b][p/2] == p[0]) eb = 1;
      chk($sformatf("R8 busy[%0d]", p), busy[p], eb);
      chk($sformatf("R9 ld_valid[%0d]", p), ld_valid[p], eld[p]);
      if (eld[p]) chk($sformatf("R9 ld_data[%0d]", p), ld_data[p], eldd[p]);
    end
    for (int b = 0; b < 2; b++) begin
      bit [NU-1:0] m = exp_mask(b);
      string tg = mhold[b] ? "R7" : "R5";
      chk($sformatf("%s cq_valid[%0d]", tg, b), cq_valid[b], m != 0);
      if (m != 0) begin
        int w = lowest(m);
        logic [15:0]  ebe = '0;
        logic [127:0] ed = '0;
        for (int u = 0; u < NU; u++) if (m[u]) begin
          ebe |= mbe[b][u];
          for (int k = 0; k < 16; k++) if (mbe[b][u][k]) ed[8*k +: 8] = mdat[b][u][8*k +: 8];
        end
        chk($sformatf("R1 %s cq_addr[%0d]", tg, b), cq_addr[b], {maddr[b][w][48:4], 4'b0});
        chk($sformatf("R5 %s cq_we[%0d]", tg, b), cq_we[b], mwe[b][w]);
        chk($sformatf("R6 cq_be[%0d]", b), cq_be[b], ebe);
        if (mwe[b][w]) chk($sformatf("R6 cq_wdata[%0d]", b), cq_wdata[b], ed);
      end
    end
  endtask

  task automatic advance_model();
    bit rdy[NU];
    for (int u = 0; u < NU; u++) rdy[u] = !(mv[0][u] || mv[1][u]);
    for (int p = 0; p < NP; p++) eld[p] = 0;
    for (int b = 0; b < 2; b++) begin
      bit [NU-1:0] m = exp_mask(b);
      if (m != 0 && cq_ready[b]) begin
        int w = lowest(m);
        if (!mwe[b][w]) begin
          eld[2*w + int'(mside[b][w])] = 1;
          eldd[2*w + int'(mside[b][w])] = cq_rdata[b];
        end
        for (int u = 0; u < NU; u++) if (m[u]) mv[b][u] = 0;
        mhold[b] = 0;
      end else begin
        mhold[b] = (m != 0);
      end
      mhm[b] = m;
    end
    for (int u = 0; u < NU; u++) begin
      eerr[u] = 0;
      if (pr_valid[u] && rdy[u]) begin
        bit both = pp_en[2*u] && pp_en[2*u+1];
        bit fault = both && ((pp_addr[2*u][48:12] != pp_addr[2*u+1][48:12])
                             || (pp_addr[2*u][4] == pp_addr[2*u+1][4]));
        if (fault) eerr[u] = 1;
        else for (int s = 0; s < 2; s++) if (pp_en[2*u+s]) begin
          int b = int'(pp_addr[2*u+s][4]);
          mv[b][u] = 1; mside[b][u] = s[0]; mwe[b][u] = pp_we[2*u+s];
          maddr[b][u] = pp_addr[2*u+s]; mbe[b][u] = pp_be[2*u+s];
          mdat[b][u] = pp_wdata[2*u+s];
        end
      end
    end
  endtask

  task automatic drive(int vpct, int rpct, int wpct, int faultpct);
    for (int u = 0; u < NU; u++) begin
      logic [36:0] up = upool[$urandom % 2];
      logic [6:0]  mid = 7'($urandom % 2);
      logic        bk = 1'($urandom);
      int          sel = int'($urandom % 100);
      pr_valid[u] = (int'($urandom % 100) < vpct);
      pp_en[2*u +: 2] = 2'($urandom % 4);
      pp_addr[2*u]   = {up, mid, bk, 4'($urandom)};
      pp_addr[2*u+1] = {up, mid + 7'd1, ~bk, 4'($urandom)};
      if (sel < faultpct / 2) pp_addr[2*u+1][4] = bk;            // R4: same-bank pair
      else if (sel < faultpct) pp_addr[2*u+1][48:12] = ~up;     // R3: upper mismatch
      for (int s = 0; s < 2; s++) begin
        pp_we[2*u+s]    = (int'($urandom % 100) < wpct);
        pp_be[2*u+s]    = ($urandom % 4 == 0) ? 16'hffff : 16'($urandom);
        pp_wdata[2*u+s] = {$urandom, $urandom, $urandom, $urandom};
      end
    end
    for (int b = 0; b < 2; b++) begin
      cq_ready[b] = (int'($urandom % 100) < rpct);
      cq_rdata[b] = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  task automatic run_phase(int n, int vpct, int rpct, int wpct, int faultpct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(vpct, rpct, wpct, faultpct);
      #1;
      compare_all();
      @(posedge clk);
      advance_model();
    end
  endtask

  initial begin
    upool[0] = 37'h0_1234_5678;
    upool[1] = 37'h1_0ABC_DEF0;
    pr_valid = '0; pp_en = '0; pp_we = '0; pp_addr = '0; pp_be = '0; pp_wdata = '0;
    cq_ready = '0; cq_rdata = '0;
    for (int b = 0; b < 2; b++) begin
      mhold[b] = 0; mhm[b] = '0;
      for (int u = 0; u < NU; u++) mv[b][u] = 0;
    end
    for (int p = 0; p < NP; p++) eld[p] = 0;
    for (int u = 0; u < NU; u++) eerr[u] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: post-reset state
    chk("R10 pr_ready", pr_ready, {NU{1'b1}});
    chk("R10 cq_valid", cq_valid, 2'b00);
    chk("R10 busy", busy, '0);
    chk("R10 ld_valid", ld_valid, '0);
    chk("R10 pair_err", pair_err, '0);
    run_phase(400, 60, 30, 80, 0);   // write-heavy, strong back-pressure: merges, R7 holds
    run_phase(400, 50, 70, 30, 0);   // read-heavy: R9 returns
    run_phase(300, 70, 60, 50, 40);  // pair faults R3 R4
    run_phase(300, 30, 100, 50, 10); // no back-pressure
    run_phase(200, 0, 100, 50, 0);   // drain
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R10 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule